// File: doc/BRIEF.md
# Global-History Correlated Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of two-bit saturating counters. It also holds a global shift register that records the outcomes of the most recent resolved branches. A fetch-side request carries the branch PC. In the same cycle the block XORs the word-address bits of that PC with the current history, reads the counter at the resulting index and returns taken or not-taken. It also returns the history value it used, so the pipeline can keep that snapshot alongside the branch. There are no tags, so different branches that map to the same entry share its counter.

When the branch resolves, the pipeline sends back the branch PC, the real outcome and the saved history snapshot. The block rebuilds the index from the snapshot rather than from the live history. It moves that counter one step toward the outcome and shifts the outcome into the history. A separate restore input can overwrite the history, for example after a pipeline flush. Both ports use valid/ready. The prediction port accepts every request and answers combinationally, with `pred_valid` equal to `pred_req_valid`. The update port holds `upd_ready` low while reset is asserted and on the first cycle after it; from then on `upd_ready` stays high. An update takes effect only on a cycle where `upd_valid` and `upd_ready` are both high. The restore input is a plain strobe.

Top module: `gbp_predictor_top`

## Requirements
- R1: After reset every counter holds 1 (weak not-taken), so every prediction is not-taken, and the history reads zero on `pred_hist`.
- R2: `pred_taken` is 1 exactly when the selected counter holds 2 or 3 (encoding: 0 strong not-taken, 1 weak not-taken, 2 weak taken, 3 strong taken). It is valid in the same cycle as the request, with `pred_valid` equal to `pred_req_valid`.
- R3: An accepted update with `upd_taken`=1 increments the indexed counter, and a counter at 3 stays at 3.
- R4: An accepted update with `upd_taken`=0 decrements the indexed counter, and a counter at 0 stays at 0.
- R5: A counter at strong taken still predicts taken after one not-taken update and predicts not-taken after a second one.
- R6: Each accepted update shifts the history left by one, with the new outcome entering bit 0 and the oldest bit dropped. Without an update or restore, the history holds its value.
- R7: Table index = `pc[IDX_W+1:2]` XOR the history zero-extended to IDX_W bits. PC bits [1:0] and bits above IDX_W+1 do not affect the index.
- R8: An update trains the entry indexed by `upd_pc` XOR `upd_hist`, not by the live history.
- R9: `hist_restore_valid` loads `hist_restore_val` into the history on the next edge and takes priority over an update's shift in the same cycle. The counter is still trained.
- R10: A prediction made in the same cycle as an update to the same entry returns the counter value from before that update.
- R11: `upd_ready` is 0 during reset and on the first cycle after it, and 1 from then on.
- R12: On a branch with a repeating taken, taken, taken, not-taken pattern, after warm-up every prediction matches the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_req_valid | input | 1 | Prediction request |
| pred_req_ready | output | 1 | Always 1; requests are never stalled |
| pred_pc | input | PC_W | Fetch PC of the branch |
| pred_valid | output | 1 | Response valid, same cycle as the request |
| pred_taken | output | 1 | Predicted direction |
| pred_hist | output | HIST_W | History used for this prediction (the snapshot) |
| upd_valid | input | 1 | Resolved-branch update offered |
| upd_ready | output | 1 | Update accepted when high together with `upd_valid` |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_hist | input | HIST_W | Snapshot returned with the prediction |
| hist_restore_valid | input | 1 | Overwrite the history |
| hist_restore_val | input | HIST_W | Value loaded into the history |

## Verification
The bench drives counters into both saturation ends and walks a strong-taken entry through two not-taken updates. A design without hysteresis or saturation would flip after one misprediction or wrap from 3 to 0. It trains with a snapshot that differs from the live history and checks which entry moved; a design that indexes updates with the live history trains the wrong entry. It also predicts and updates the same entry in one cycle, where a write-first table would return the new value. It sets the low PC bits and the bits above the index field, which would scatter entries if those bits reached the index. Finally it runs a four-beat loop pattern that a design with a broken history shift would never learn.

// File: rtl/gbp_pkg.sv
package gbp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'd0;
  localparam ctr_t CTR_WEAK_NT   = 2'd1;
  localparam ctr_t CTR_WEAK_T    = 2'd2;
  localparam ctr_t CTR_STRONG_T  = 2'd3;

  // move one step toward the observed outcome, clamped at both ends
  function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : ctr_t'(cur + 2'd1);
    else       nxt = (cur == CTR_STRONG_NT) ? cur : ctr_t'(cur - 2'd1);
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/gbp_index.sv
module gbp_index #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic [IDX_W-1:0]  pc_bits,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] hist_ext;

  generate
    if (HIST_W == IDX_W) begin : g_full
      assign hist_ext = hist;
    end else begin : g_pad
      assign hist_ext = {{(IDX_W-HIST_W){1'b0}}, hist};
    end
  endgenerate

  assign idx = pc_bits ^ hist_ext;
endmodule

// File: rtl/gbp_history.sv
module gbp_history #(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              load_en,
  input  logic [HIST_W-1:0] load_val,
  output logic [HIST_W-1:0] hist_q
);
  logic [HIST_W-1:0] shifted;

  generate
    if (HIST_W == 1) begin : g_one
      assign shifted = shift_bit;
    end else begin : g_many
      assign shifted = {hist_q[HIST_W-2:0], shift_bit};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (load_en)  hist_q <= load_val;
    else if (shift_en) hist_q <= shifted;
  end
endmodule

// File: rtl/gbp_ctr_table.sv
module gbp_ctr_table
  import gbp_pkg::*;
#(
  parameter int ENTRIES = 1024,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output ctr_t             wr_cur,
  output ctr_t             wr_next
);
  ctr_t mem [ENTRIES];

  // both reads see the array before this edge's write
  assign rd_ctr  = mem[rd_idx];
  assign wr_cur  = mem[wr_idx];
  assign wr_next = ctr_train(wr_cur, wr_taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_next;
    end
  end
endmodule

// File: rtl/gbp_predictor_top.sv
module gbp_predictor_top
  import gbp_pkg::*;
#(
  parameter int ENTRIES = 1024,
  parameter int HIST_W  = 10,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pred_req_valid,
  output logic              pred_req_ready,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              hist_restore_valid,
  input  logic [HIST_W-1:0] hist_restore_val
);
  logic [HIST_W-1:0] ghr;
  logic [IDX_W-1:0]  pred_idx;
  logic [IDX_W-1:0]  upd_idx;
  ctr_t              pred_ctr;
  ctr_t              upd_cur;
  ctr_t              upd_next;
  logic              upd_fire;
  logic              ready_q;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign upd_ready      = ready_q;
  assign upd_fire       = upd_valid & ready_q;
  assign pred_req_ready = 1'b1;
  assign pred_valid     = pred_req_valid;

  gbp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_pred_index (
    .pc_bits (pred_pc[IDX_W+1:2]),
    .hist    (ghr),
    .idx     (pred_idx)
  );

  gbp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_upd_index (
    .pc_bits (upd_pc[IDX_W+1:2]),
    .hist    (upd_hist),
    .idx     (upd_idx)
  );

  gbp_ctr_table #(.ENTRIES(ENTRIES)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (pred_idx),
    .rd_ctr   (pred_ctr),
    .wr_en    (upd_fire),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken),
    .wr_cur   (upd_cur),
    .wr_next  (upd_next)
  );

  gbp_history #(.HIST_W(HIST_W)) u_history (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (upd_fire),
    .shift_bit (upd_taken),
    .load_en   (hist_restore_valid),
    .load_val  (hist_restore_val),
    .hist_q    (ghr)
  );

  assign pred_taken = ctr_says_taken(pred_ctr);
  assign pred_hist  = ghr;
endmodule

// File: rtl/gbp_predictor_chk.sv
module gbp_predictor_chk
  import gbp_pkg::*;
#(
  parameter int HIST_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              upd_valid,
  input logic              upd_ready,
  input logic              upd_taken,
  input ctr_t              upd_cur,
  input ctr_t              upd_next,
  input logic [HIST_W-1:0] pred_hist,
  input logic              hist_restore_valid,
  input logic [HIST_W-1:0] hist_restore_val
);
  logic fire;
  assign fire = upd_valid & upd_ready;

  // R3
  sat_high_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && upd_taken && upd_cur == CTR_STRONG_T) |-> (upd_next == CTR_STRONG_T));

  // R4
  sat_low_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !upd_taken && upd_cur == CTR_STRONG_NT) |-> (upd_next == CTR_STRONG_NT));

  // R5
  hysteresis_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !upd_taken && upd_cur == CTR_STRONG_T) |-> (upd_next == CTR_WEAK_T));

  // R6
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fire && !hist_restore_valid) |=> $stable(pred_hist));

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !hist_restore_valid) |=> (pred_hist[0] == $past(upd_taken)));

  // R9
  hist_restore_chk: assert property (@(posedge clk) disable iff (rst)
    hist_restore_valid |=> (pred_hist == $past(hist_restore_val)));

  // R11
  ready_up_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> upd_ready);
endmodule

bind gbp_predictor_top gbp_predictor_chk #(.HIST_W(HIST_W)) u_chk (
  .clk                (clk),
  .rst                (rst),
  .upd_valid          (upd_valid),
  .upd_ready          (upd_ready),
  .upd_taken          (upd_taken),
  .upd_cur            (upd_cur),
  .upd_next           (upd_next),
  .pred_hist          (pred_hist),
  .hist_restore_valid (hist_restore_valid),
  .hist_restore_val   (hist_restore_val)
);

// File: tb/gbp_predictor_top_tb.sv
module gbp_predictor_top_tb;
  localparam int ENTRIES = 1024;
  localparam int HIST_W  = 10;
  localparam int PC_W    = 32;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pred_req_valid = 1'b0;
  logic              pred_req_ready;
  logic [PC_W-1:0]   pred_pc = '0;
  logic              pred_valid;
  logic              pred_taken;
  logic [HIST_W-1:0] pred_hist;
  logic              upd_valid = 1'b0;
  logic              upd_ready;
  logic [PC_W-1:0]   upd_pc = '0;
  logic              upd_taken = 1'b0;
  logic [HIST_W-1:0] upd_hist = '0;
  logic              hist_restore_valid = 1'b0;
  logic [HIST_W-1:0] hist_restore_val = '0;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int ref_cnt [ENTRIES];
  logic [HIST_W-1:0] ref_ghr;
  logic last_pred;

  always #10 clk = ~clk;

  gbp_predictor_top #(.ENTRIES(ENTRIES), .HIST_W(HIST_W), .PC_W(PC_W)) u_dut (
    .clk(clk), .rst(rst),
    .pred_req_valid(pred_req_valid), .pred_req_ready(pred_req_ready),
    .pred_pc(pred_pc), .pred_valid(pred_valid), .pred_taken(pred_taken),
    .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist),
    .hist_restore_valid(hist_restore_valid), .hist_restore_val(hist_restore_val)
  );

  function automatic int ref_idx(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
    logic [IDX_W-1:0] hx;
    hx = IDX_W'(h);
    return int'(pc[IDX_W+1:2] ^ hx);
  endfunction

  function automatic int ref_next(input int c, input logic t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational response, advance model at posedge
  task automatic step(input logic pv, input logic [PC_W-1:0] ppc,
                      input logic uv, input logic [PC_W-1:0] upc, input logic ut,
                      input logic [HIST_W-1:0] uh,
                      input logic rv, input logic [HIST_W-1:0] rval,
                      input bit chk, input string req);
    int exp_pred;
    @(negedge clk);
    pred_req_valid = pv; pred_pc = ppc;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_hist = uh;
    hist_restore_valid = rv; hist_restore_val = rval;
    #2;
    last_pred = pred_taken;
    if (chk) begin
      exp_pred = (ref_cnt[ref_idx(ppc, ref_ghr)] >= 2) ? 1 : 0;
      check(req, pred_taken, exp_pred);
      check("R6 history", pred_hist, ref_ghr);
      check("R2 valid", pred_valid, pv);
    end
    @(posedge clk);
    if (uv && upd_ready) ref_cnt[ref_idx(upc, uh)] = ref_next(ref_cnt[ref_idx(upc, uh)], ut);
    if (rv) ref_ghr = rval;
    else if (uv && upd_ready) ref_ghr = {ref_ghr[HIST_W-2:0], ut};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [PC_W-1:0] pa;
    logic [PC_W-1:0] pl;
    int miss;
    int seed;
    seed = 17;
    void'($urandom(seed));
    for (int i = 0; i < ENTRIES; i++) ref_cnt[i] = 1;
    ref_ghr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    // R11: ready still low on the first cycle after reset
    check("R11 ready after reset", upd_ready, 0);
    @(negedge clk);
    #2;
    check("R11 ready steady", upd_ready, 1);
    check("R2 req ready", pred_req_ready, 1);

    // R1: reset state
    for (int k = 0; k < 6; k++)
      step(1, PC_W'(k * 1236), 0, '0, 0, '0, 0, '0, 1, "R1 reset predicts not-taken");
    check("R1 history zero", pred_hist, 0);

    // R3 / R5 / R4: keep history at zero by restoring it each cycle
    pa = 32'h0000_0120;
    for (int k = 0; k < 5; k++)
      step(1, pa, 1, pa, 1, '0, 1, '0, 1, "R3 train taken");
    step(1, pa, 0, '0, 0, '0, 0, '0, 1, "R3 saturated taken");
    check("R3 predicts taken", last_pred, 1);
    step(1, pa, 1, pa, 0, '0, 1, '0, 1, "R5 before first miss");
    step(1, pa, 0, '0, 0, '0, 0, '0, 1, "R5 one miss");
    check("R5 still taken after one miss", last_pred, 1);
    step(1, pa, 1, pa, 0, '0, 1, '0, 1, "R5 second miss");
    step(1, pa, 0, '0, 0, '0, 0, '0, 1, "R5 two misses");
    check("R5 flips after two misses", last_pred, 0);
    for (int k = 0; k < 4; k++)
      step(1, pa, 1, pa, 0, '0, 1, '0, 1, "R4 train not-taken");
    step(1, pa, 1, pa, 1, '0, 1, '0, 1, "R4 one taken from floor");
    step(1, pa, 0, '0, 0, '0, 0, '0, 1, "R4 floor then one taken");
    check("R4 saturated low stays not-taken", last_pred, 0);

    // R7: low and high PC bits ignored
    pa = 32'h0000_0340;
    step(1, pa, 1, pa, 1, '0, 1, '0, 1, "R7 train");
    step(1, pa, 1, pa, 1, '0, 1, '0, 1, "R7 train");
    step(1, pa | 32'h3, 0, '0, 0, '0, 0, '0, 1, "R7 low bits");
    check("R7 low PC bits ignored", last_pred, 1);
    step(1, pa | 32'h0010_0000, 0, '0, 0, '0, 0, '0, 1, "R7 high bits");
    check("R7 high PC bits ignored", last_pred, 1);

    // R8: update trains snapshot entry, not live history entry
    pa = 32'h0000_0800;
    step(0, '0, 0, '0, 0, '0, 1, 10'd5, 0, "R8 set");
    step(1, pa, 1, pa, 1, '0, 1, 10'd5, 1, "R8 train snapshot");
    step(1, pa, 1, pa, 1, '0, 1, 10'd5, 1, "R8 train snapshot");
    step(1, pa, 0, '0, 0, '0, 0, '0, 1, "R8 live entry");
    check("R8 live-history entry untouched", last_pred, 0);
    step(0, '0, 0, '0, 0, '0, 1, '0, 0, "R8 restore");
    step(1, pa, 0, '0, 0, '0, 0, '0, 1, "R8 snapshot entry");
    check("R8 snapshot entry trained", last_pred, 1);

    // R9: restore wins over shift
    step(0, '0, 1, 32'h44, 1, '0, 1, 10'h2AA, 0, "R9");
    step(1, '0, 0, '0, 0, '0, 0, '0, 1, "R9 restore priority");
    check("R9 history loaded", pred_hist, 10'h2AA);

    // R10: predict and update same entry in one cycle
    pa = 32'h0000_0E00;
    step(0, '0, 0, '0, 0, '0, 1, '0, 0, "R10 set");
    step(1, pa, 1, pa, 1, '0, 1, '0, 1, "R10 same-cycle");
    check("R10 old value seen", last_pred, 0);
    step(1, pa, 1, pa, 1, '0, 1, '0, 1, "R10 same-cycle");
    check("R10 still old value", last_pred, 1);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] rp;
      logic [PC_W-1:0] up;
      rp = PC_W'($urandom) & 32'h0000_0FFC;
      up = ($urandom_range(0, 1) == 1) ? rp : (PC_W'($urandom) & 32'h0000_0FFC);
      step(1, rp, $urandom_range(0, 3) != 0, up, $urandom_range(0, 1) == 1,
           HIST_W'($urandom), $urandom_range(0, 15) == 0, HIST_W'($urandom),
           1, "R2 random");
    end

    // R12: loop pattern T,T,T,N; resolve in the same cycle with the snapshot
    pl = 32'h0000_0A40;
    miss = 0;
    for (int n = 0; n < 160; n++) begin
      logic out;
      out = (n % 4) != 3;
      step(1, pl, 1, pl, out, ref_ghr, 0, '0, 1, "R12 loop model");
      if (n >= 80 && last_pred != out) miss++;
    end
    check("R12 no mispredict after warm-up", miss, 0);

    finish_run();
  end
endmodule